// File: doc/BRIEF.md
# Split-Tenure Bus Arbiter

This block is the central arbiter for a processor bus that runs address and data phases as separate tenures. It serves four masters: one on-chip master and three external masters. Each master raises a request line. The arbiter answers with one address-grant line and one data-grant line per master. A programmable level per master sets preference. Masters that share the top level take turns. When nobody requests, the address grant rests on a master chosen by a configuration field.

The arbiter watches the tenure-start strobe, the address acknowledge and the retry line. From these it records which master owns each address tenure. Each acknowledged tenure goes into a small in-order queue. The queue head receives the data grant, but only while the data bus is idle and no retry is signalled. An address tenure begins only when the strobe arrives while address-busy and retry are both low.

Top module: `bus_arb_top`

## Requirements
- R1: At most one address-grant bit is high at any time. While reset is held and on the first clock after reset is released, all address and data grants are low.
- R2: When no request is present, the address grant on the following clock goes to the master whose index is in `park_id` (index i drives bit i). This includes a change of `park_id` while the bus is idle.
- R3: Among the requesting masters, the grant goes to the one with the numerically highest level. The level of master i is `prio_cfg[3*i+2:3*i]`, and 7 is the most preferred.
- R4: Requesters that tie at the top level are served round-robin. The search starts at the master after the one whose address tenure began most recently. After reset the search starts at master 0.
- R5: A tenure start (`ts` high while the grant is held, with `abusy` and `artry` low) removes the grant from the current owner on the next clock. If another master requests, the grant passes to it; otherwise it goes to the park master.
- R6: A `ts` pulse seen while `abusy` or `artry` is high does not start a tenure and leaves the grant unchanged.
- R7: An `aack` without `artry` enqueues the owner of the open address tenure. Data grants then follow the order in which the tenures were acknowledged. An `aack` together with `artry` cancels the tenure and enqueues nothing.
- R8: No data-grant bit is high while `dbusy` or `artry` is high.
- R9: `dts` while a data grant is high ends that grant. On the same clock the data grant moves to the next queued master, or is removed if the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 4 | Address-bus request, one bit per master |
| prio_cfg | input | 12 | Three-bit request level per master |
| park_id | input | 2 | Master that holds the grant when the bus is idle |
| ts | input | 1 | Address tenure start strobe |
| abusy | input | 1 | Address bus busy |
| dbusy | input | 1 | Data bus busy |
| artry | input | 1 | Address retry |
| aack | input | 1 | Address acknowledge |
| dts | input | 1 | Data tenure start strobe |
| abg | output | 4 | Address grant, one-hot or zero |
| dbg | output | 4 | Data grant, one-hot or zero |

## Verification
The bench rotates the grant through four masters at equal level, including the wrap from master 3 back to 0. A pointer that never advanced, or that started in the wrong place, would grant the same master twice or skip one. It sends tenure-start strobes while busy or retry is asserted: a design that ignored qualification would move the grant. It also sends an acknowledge together with retry, which a faulty queue would record as a phantom data tenure. Data-grant order across two queued tenures is checked to catch a queue that serves out of order. Data grants are also checked while the data bus is busy, to catch grants that leak through.

// File: rtl/arb_pkg.sv
// Shared constants and types for the split-tenure bus arbiter.
// Assumes a request level fits in three bits (eight levels).
package arb_pkg;
    localparam int unsigned LVL_W = 3;
    typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/arb_pick.sv
// Winner selection: finds the highest level among the masked requesters,
// then picks the first master at that level, scanning from the one after lptr.
// Assumes NM >= 2. The output is valid only when any_o is high.
module arb_pick
    import arb_pkg::*;
#(
    parameter int unsigned NM  = 4,
    parameter int unsigned IDW = $clog2(NM)
) (
    input  logic [NM-1:0]       req_i,
    input  logic [NM*LVL_W-1:0] lvl_i,
    input  logic [IDW-1:0]      lptr_i,
    output logic                any_o,
    output logic [IDW-1:0]      win_o
);
    lvl_t maxl;

    // Find the highest level among the active requests.
    always_comb begin
        maxl  = '0;
        any_o = 1'b0;
        for (int i = 0; i < NM; i++) begin
            if (req_i[i]) begin
                any_o = 1'b1;
                if (lvl_i[i*LVL_W +: LVL_W] > maxl) maxl = lvl_i[i*LVL_W +: LVL_W];
            end
        end
    end

    // Round-robin scan among the requesters at the top level.
    always_comb begin
        logic found;
        found = 1'b0;
        win_o = '0;
        for (int k = 1; k <= NM; k++) begin
            int j;
            j = (int'(lptr_i) + k) % int'(NM);
            if (!found && req_i[j] && lvl_i[j*LVL_W +: LVL_W] == maxl) begin
                found = 1'b1;
                win_o = IDW'(j);
            end
        end
    end
endmodule

// File: rtl/arb_fifo.sv
// In-order queue of master indices waiting for a data tenure.
// Assumes the caller never pushes while full. Push and pop may occur together.
module arb_fifo #(
    parameter int unsigned W     = 2,
    parameter int unsigned DEPTH = 4,
    parameter int unsigned PW    = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o,
    output logic         empty_o,
    output logic         full_o,
    output logic [PW:0]  count_o
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rp, wp;

    assign head_o  = mem[rp];
    assign empty_o = (count_o == '0);
    assign full_o  = (count_o == (PW+1)'(DEPTH));

    // Move the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp      <= '0;
            wp      <= '0;
            count_o <= '0;
        end else begin
            if (push_i) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (pop_i)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
            count_o <= count_o + (PW+1)'(push_i) - (PW+1)'(pop_i);
        end
    end

    // Store the entry being pushed.
    always_ff @(posedge clk) begin
        if (push_i) mem[wp] <= data_i;
    end
endmodule

// File: rtl/bus_arb_top.sv
// Split-tenure bus arbiter top level. It issues a registered one-hot address
// grant and a data grant driven from the head of the in-order queue.
// Assumes at most one address tenure is open at a time and that aack follows ts.
module bus_arb_top
    import arb_pkg::*;
#(
    parameter int unsigned NM     = 4,
    parameter int unsigned QDEPTH = 4,
    localparam int unsigned IDW   = $clog2(NM),
    localparam int unsigned QPW   = $clog2(QDEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NM-1:0]       req,
    input  logic [NM*LVL_W-1:0] prio_cfg,
    input  logic [IDW-1:0]      park_id,
    input  logic                ts,
    input  logic                abusy,
    input  logic                dbusy,
    input  logic                artry,
    input  logic                aack,
    input  logic                dts,
    output logic [NM-1:0]       abg,
    output logic [NM-1:0]       dbg
);
    logic [IDW-1:0] owner, lptr, aown, win, qhead;
    logic           ts_ok, any, aopen, push, pop, qempty, qfull;
    logic [NM-1:0]  cand;
    logic [QPW:0]   qcount;

    // Encode the current address-grant holder as an index.
    always_comb begin
        owner = '0;
        for (int i = 0; i < NM; i++) if (abg[i]) owner = IDW'(i);
    end

    assign ts_ok = ts && (|abg) && !abusy && !artry;
    assign cand  = ts_ok ? (req & ~abg) : req;

    arb_pick #(.NM(NM), .IDW(IDW)) u_pick (
        .req_i(cand), .lvl_i(prio_cfg), .lptr_i(lptr), .any_o(any), .win_o(win)
    );

    // Register the address grant: the winner, or the park master when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) abg <= '0;
        else        abg <= any ? (NM'(1) << win) : (NM'(1) << park_id);
    end

    // Track the round-robin pointer and the open address tenure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lptr  <= IDW'(NM-1);
            aown  <= '0;
            aopen <= 1'b0;
        end else if (ts_ok) begin
            lptr  <= owner;
            aown  <= owner;
            aopen <= 1'b1;
        end else if (aack) begin
            aopen <= 1'b0;
        end
    end

    assign push = aack && aopen && !artry && !qfull;
    assign pop  = dts && (|dbg);

    arb_fifo #(.W(IDW), .DEPTH(QDEPTH)) u_q (
        .clk(clk), .rst_n(rst_n), .push_i(push), .data_i(aown), .pop_i(pop),
        .head_o(qhead), .empty_o(qempty), .full_o(qfull), .count_o(qcount)
    );

    // Grant the data bus to the queue head while the bus is free of busy and retry.
    always_comb begin
        dbg = '0;
        if (!qempty && !dbusy && !artry) dbg = NM'(1) << qhead;
    end
endmodule

// File: rtl/arb_chk.sv
// Property checker for bus_arb_top, bound into every instance of it.
// Watches the top ports plus the queue-full flag and the open-tenure flag.
module arb_chk #(
    parameter int unsigned NM  = 4,
    parameter int unsigned IDW = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NM-1:0]  req,
    input logic [IDW-1:0] park_id,
    input logic           ts,
    input logic           abusy,
    input logic           dbusy,
    input logic           artry,
    input logic           aack,
    input logic [NM-1:0]  abg,
    input logic [NM-1:0]  dbg,
    input logic           qfull,
    input logic           aopen
);
    // R1
    abg_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(abg));
    // R1
    grant_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (abg == '0 && dbg == '0));
    // R2
    park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |=> (abg == (NM'(1) << $past(park_id))));
    // R5
    handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ts && |abg && !abusy && !artry && |(req & ~abg)) |=> (abg != $past(abg)));
    // R8
    dgate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbusy || artry) |-> (dbg == '0));
    // R9
    dbg_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(dbg));
    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(aack && aopen && !artry && qfull));
endmodule

bind bus_arb_top arb_chk #(.NM(NM), .IDW(IDW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .park_id(park_id), .ts(ts),
    .abusy(abusy), .dbusy(dbusy), .artry(artry), .aack(aack),
    .abg(abg), .dbg(dbg), .qfull(qfull), .aopen(aopen)
);

// File: tb/sim_bus_arb_top.sv
module sim_bus_arb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  req;
    logic [11:0] prio_cfg;
    logic [1:0]  park_id;
    logic        ts, abusy, dbusy, artry, aack, dts;
    logic [3:0]  abg, dbg;
    int          n_chk = 0;
    int          n_err = 0;

    always #5 clk = ~clk;

    bus_arb_top u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .prio_cfg(prio_cfg), .park_id(park_id),
        .ts(ts), .abusy(abusy), .dbusy(dbusy), .artry(artry), .aack(aack), .dts(dts),
        .abg(abg), .dbg(dbg)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] pk);
        @(negedge clk);
        rst_n = 1'b0; req = '0; prio_cfg = '0; park_id = pk;
        ts = 0; abusy = 0; dbusy = 0; artry = 0; aack = 0; dts = 0;
        cyc(); cyc();
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset(2'd2);
        rst_n = 1'b0; #1;
        chk("R1 abg in reset", abg, 4'b0000);
        chk("R1 dbg in reset", dbg, 4'b0000);
        rst_n = 1'b1;
        cyc();
        chk("R2 park after reset", abg, 4'b0100);
        park_id = 2'd1; cyc();
        chk("R2 park change", abg, 4'b0010);
    endtask

    task automatic t_prio();
        do_reset(2'd0);
        prio_cfg = {3'd0, 3'd3, 3'd5, 3'd1};
        req = 4'b1111; cyc();
        chk("R3 level 5 wins", abg, 4'b0010);
        req = 4'b0101; cyc();
        chk("R3 level 3 beats 1", abg, 4'b0100);
        prio_cfg = {3'd7, 3'd3, 3'd5, 3'd1};
        req = 4'b1111; cyc();
        chk("R3 level 7 wins", abg, 4'b1000);
    endtask

    task automatic t_rr();
        logic [3:0] exp;
        do_reset(2'd0);
        prio_cfg = {4{3'd4}};
        req = 4'b1111; cyc();
        chk("R4 rr first", abg, 4'b0001);
        exp = 4'b0001;
        for (int k = 0; k < 4; k++) begin
            ts = 1'b1; cyc(); ts = 1'b0;
            exp = {exp[2:0], exp[3]};
            chk("R4 R5 rr handoff", abg, exp);
            cyc();
            chk("R4 rr hold", abg, exp);
        end
        req = 4'b0001; cyc();
        chk("R5 sole requester", abg, 4'b0001);
        ts = 1'b1; cyc(); ts = 1'b0;
        chk("R5 to park when alone", abg, 4'b0001);
    endtask

    task automatic t_ignore();
        do_reset(2'd3);
        prio_cfg = {4{3'd2}};
        req = 4'b1111; cyc();
        chk("R6 setup", abg, 4'b0001);
        abusy = 1'b1; ts = 1'b1; cyc(); ts = 1'b0; abusy = 1'b0;
        chk("R6 ts under abusy", abg, 4'b0001);
        artry = 1'b1; ts = 1'b1; cyc(); ts = 1'b0; artry = 1'b0;
        chk("R6 ts under artry", abg, 4'b0001);
        aack = 1'b1; cyc(); aack = 1'b0;
        chk("R6 no tenure queued", dbg, 4'b0000);
    endtask

    task automatic t_data();
        do_reset(2'd0);
        prio_cfg = {4{3'd1}};
        req = 4'b0011; cyc();
        ts = 1'b1; cyc(); ts = 1'b0;
        aack = 1'b1; artry = 1'b1; cyc(); aack = 1'b0; artry = 1'b0;
        chk("R7 retried aack dropped", dbg, 4'b0000);
        req = 4'b1010; cyc();
        chk("R7 grant m1", abg, 4'b0010);
        ts = 1'b1; cyc(); ts = 1'b0;
        aack = 1'b1; cyc(); aack = 1'b0;
        chk("R7 first data grant", dbg, 4'b0010);
        chk("R7 grant m3", abg, 4'b1000);
        ts = 1'b1; cyc(); ts = 1'b0;
        aack = 1'b1; cyc(); aack = 1'b0;
        chk("R7 order kept", dbg, 4'b0010);
        dbusy = 1'b1; #1;
        chk("R8 dbusy gates", dbg, 4'b0000);
        dts = 1'b1; cyc(); dts = 1'b0;
        chk("R9 no pop when gated", dbg, 4'b0000);
        dbusy = 1'b0; artry = 1'b1; #1;
        chk("R8 artry gates", dbg, 4'b0000);
        artry = 1'b0; #1;
        chk("R8 released", dbg, 4'b0010);
        dts = 1'b1; cyc(); dts = 1'b0;
        chk("R9 next in queue", dbg, 4'b1000);
        dts = 1'b1; cyc(); dts = 1'b0;
        chk("R9 queue drained", dbg, 4'b0000);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_prio();
                t_rr();
                t_ignore();
                t_data();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule